// File: doc/BRIEF.md
# BCD and ASCII Adjust Unit

This unit performs the four accumulator correction steps that an 8086-class integer core runs after byte arithmetic on packed or unpacked decimal data. It handles decimal correction after addition or subtraction and ASCII correction after addition or subtraction. The core's decode stage presents the low accumulator byte (AL), the high accumulator byte (AH), the incoming carry and half-carry flags, and a two-bit operation code, then pulses `start`.

The unit captures these inputs and computes the result in the cycle `start` is accepted. It holds the result in output registers. It then stays busy for a fixed number of cycles that depends on the operation class. It pulses `done` for one cycle when that time has run out. A `start` that arrives while the unit is busy is dropped. The result outputs keep their value until the next accepted `start`.

Top module: `bcd_adj_unit`

## Requirements
- R1: While reset is held, and after it is released until the first accepted start, `busy`, `done` and every result output read 0.
- R2: Decimal add (op 2'b00): if half-carry in is 1 or AL[3:0] > 9, AL gains 0x06 and half-carry out is 1. Otherwise half-carry out equals half-carry in.
- R3: Decimal add: if carry in is 1 or the AL sampled at start is above 0x99, AL also gains 0x60 and carry out is 1. Otherwise carry out equals carry in. Both conditions use the sampled AL and flags, never the partly corrected value.
- R4: Decimal subtract (op 2'b01) uses the same two conditions and flag rules as R2 and R3, but subtracts 0x06 and 0x60 instead of adding them.
- R5: For every operation, the sign output is the final AL bit 7. The zero output is 1 when the final AL is 0. The parity output is 1 when the final AL has an even number of one bits.
- R6: ASCII add (op 2'b10): if half-carry in is 1 or AL[3:0] > 9, AL gains 0x06, AH gains 1, and carry and half-carry out are both 1. Otherwise both are 0 and AH is unchanged.
- R7: ASCII subtract (op 2'b11): the same as R6, but AL loses 0x06 and AH loses 1.
- R8: After either ASCII operation, AL[7:4] is 0.
- R9: `busy` is high from the cycle after an accepted start. `done` rises exactly DEC_CYCLES clock edges after the accepting edge for decimal operations, and ASC_CYCLES edges after it for ASCII operations. `done` lasts one cycle, and `busy` is low in that cycle.
- R10: A start raised while `busy` is high has no effect on the results, on the timing of `done`, or on the number of `done` pulses.
- R11: The result outputs keep their value from an accepted start until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin an operation; accepted only while not busy |
| op | input | 2 | 00 decimal add, 01 decimal subtract, 10 ASCII add, 11 ASCII subtract |
| al_in | input | 8 | Accumulator low byte |
| ah_in | input | 8 | Accumulator high byte |
| cf_in | input | 1 | Incoming carry |
| hf_in | input | 1 | Incoming half-carry |
| al_out | output | 8 | Corrected low byte |
| ah_out | output | 8 | Corrected high byte |
| cf_out | output | 1 | Carry out |
| hf_out | output | 1 | Half-carry out |
| sf_out | output | 1 | Sign of final AL |
| zf_out | output | 1 | Final AL is zero |
| pf_out | output | 1 | Even parity of final AL |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the unit with its default latencies of 9 and 8 cycles. Because these two values differ, a swap between the decimal and ASCII classes shows up as `done` arriving one cycle early or late. Both values are large enough that a start can be injected well inside a busy window, which exercises the dropped-start rule. The vectors cover each correction condition alone and the two conditions together, with and without incoming flags, and include borrows that wrap AL and AH past zero.

// File: rtl/bcd_adj_pkg.sv
package bcd_adj_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = BYTE_W / 2;

  typedef enum logic [1:0] {
    OP_DEC_ADD = 2'b00,
    OP_DEC_SUB = 2'b01,
    OP_ASC_ADD = 2'b10,
    OP_ASC_SUB = 2'b11
  } adj_op_e;

  typedef struct packed {
    logic [BYTE_W-1:0] al;
    logic [BYTE_W-1:0] ah;
    logic              cf;
    logic              hf;
    logic              sf;
    logic              zf;
    logic              pf;
  } adj_res_t;
endpackage

// File: rtl/bcd_adj_core.sv
module bcd_adj_core
  import bcd_adj_pkg::*;
(
  input  adj_op_e           op,
  input  logic [BYTE_W-1:0] al_i,
  input  logic [BYTE_W-1:0] ah_i,
  input  logic              cf_i,
  input  logic              hf_i,
  output adj_res_t          res
);
  localparam logic [BYTE_W-1:0] LO_STEP = BYTE_W'(8'h06);
  localparam logic [BYTE_W-1:0] HI_STEP = BYTE_W'(8'h60);
  localparam logic [BYTE_W-1:0] HI_LIM  = BYTE_W'(8'h99);

  logic              lo_fix, hi_fix, is_sub, is_asc;
  logic [BYTE_W-1:0] al_t, ah_t;
  logic              cf_t, hf_t;

  always_comb begin
    lo_fix = hf_i || (al_i[NIB_W-1:0] > NIB_W'(9));
    hi_fix = cf_i || (al_i > HI_LIM);
    is_sub = (op == OP_DEC_SUB) || (op == OP_ASC_SUB);
    is_asc = (op == OP_ASC_ADD) || (op == OP_ASC_SUB);
    al_t   = al_i;
    ah_t   = ah_i;
    cf_t   = cf_i;
    hf_t   = hf_i;
    if (!is_asc) begin
      if (lo_fix) begin
        al_t = is_sub ? al_t - LO_STEP : al_t + LO_STEP;
        hf_t = 1'b1;
      end
      if (hi_fix) begin
        al_t = is_sub ? al_t - HI_STEP : al_t + HI_STEP;
        cf_t = 1'b1;
      end
    end else begin
      if (lo_fix) begin
        al_t = is_sub ? al_t - LO_STEP : al_t + LO_STEP;
        ah_t = is_sub ? ah_t - 1'b1 : ah_t + 1'b1;
      end
      cf_t = lo_fix;
      hf_t = lo_fix;
      al_t = {{(BYTE_W-NIB_W){1'b0}}, al_t[NIB_W-1:0]};
    end
    res.al = al_t;
    res.ah = ah_t;
    res.cf = cf_t;
    res.hf = hf_t;
    res.sf = al_t[BYTE_W-1];
    res.zf = (al_t == '0);
    res.pf = ~^al_t;
  end
endmodule

// File: rtl/bcd_adj_timer.sv
module bcd_adj_timer #(
  parameter int DEC_CYCLES = 9,
  parameter int ASC_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic is_asc,
  output logic busy,
  output logic done
);
  localparam int MAX_C = (DEC_CYCLES > ASC_CYCLES) ? DEC_CYCLES : ASC_CYCLES;
  localparam int CNT_W = (MAX_C > 1) ? $clog2(MAX_C) : 1;
  localparam logic [CNT_W-1:0] DEC_LOAD = CNT_W'(DEC_CYCLES - 1);
  localparam logic [CNT_W-1:0] ASC_LOAD = CNT_W'(ASC_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d, done_q, done_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (load) begin
      cnt_d  = is_asc ? ASC_LOAD : DEC_LOAD;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
endmodule

// File: rtl/bcd_adj_unit.sv
module bcd_adj_unit
  import bcd_adj_pkg::*;
#(
  parameter int DEC_CYCLES = 9,
  parameter int ASC_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] op,
  input  logic [7:0] al_in,
  input  logic [7:0] ah_in,
  input  logic       cf_in,
  input  logic       hf_in,
  output logic [7:0] al_out,
  output logic [7:0] ah_out,
  output logic       cf_out,
  output logic       hf_out,
  output logic       sf_out,
  output logic       zf_out,
  output logic       pf_out,
  output logic       busy,
  output logic       done
);
  logic     rst_meta_n, rst_sync_n;
  logic     accept;
  adj_op_e  op_sel;
  adj_op_e  op_q;
  adj_res_t res_d, res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  assign op_sel = adj_op_e'(op);
  assign accept = start && !busy;

  bcd_adj_core u_core (
    .op   (op_sel),
    .al_i (al_in),
    .ah_i (ah_in),
    .cf_i (cf_in),
    .hf_i (hf_in),
    .res  (res_d)
  );

  bcd_adj_timer #(
    .DEC_CYCLES (DEC_CYCLES),
    .ASC_CYCLES (ASC_CYCLES)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load   (accept),
    .is_asc (op[1]),
    .busy   (busy),
    .done   (done)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q <= '0;
      op_q  <= OP_DEC_ADD;
    end else if (accept) begin
      res_q <= res_d;
      op_q  <= op_sel;
    end
  end

  assign al_out = res_q.al;
  assign ah_out = res_q.ah;
  assign cf_out = res_q.cf;
  assign hf_out = res_q.hf;
  assign sf_out = res_q.sf;
  assign zf_out = res_q.zf;
  assign pf_out = res_q.pf;
endmodule

// File: rtl/bcd_adj_unit_chk.sv
module bcd_adj_unit_chk #(
  parameter int DEC_CYCLES = 9,
  parameter int ASC_CYCLES = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [1:0] op,
  input logic [1:0] op_q,
  input logic       busy,
  input logic       done,
  input logic [7:0] al_out,
  input logic [7:0] ah_out,
  input logic       zf_out
);
  logic [15:0] since_q, want_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;
      want_q  <= '0;
    end else if (start && !busy) begin
      since_q <= '0;
      want_q  <= op[1] ? 16'(ASC_CYCLES) : 16'(DEC_CYCLES);
    end else if (busy) begin
      since_q <= since_q + 1'b1;
    end
  end

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> since_q == want_q);
  a_r8_ascii_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q[1]) |-> al_out[7:4] == 4'h0);
  a_r10_start_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(al_out) && $stable(ah_out)));
  a_r11_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(al_out));
  a_r5_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> zf_out == (al_out == 8'h00));
endmodule

bind bcd_adj_unit bcd_adj_unit_chk #(
  .DEC_CYCLES (DEC_CYCLES),
  .ASC_CYCLES (ASC_CYCLES)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .start  (start),
  .op     (op),
  .op_q   (op_q),
  .busy   (busy),
  .done   (done),
  .al_out (al_out),
  .ah_out (ah_out),
  .zf_out (zf_out)
);

// File: tb/bcd_adj_unit_test.sv
module bcd_adj_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEC = 9;
  localparam int ASC = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic [1:0] op;
  logic [7:0] al_in, ah_in;
  logic cf_in, hf_in;
  logic [7:0] al_out, ah_out;
  logic cf_out, hf_out, sf_out, zf_out, pf_out, busy, done;

  bcd_adj_unit #(.DEC_CYCLES(DEC), .ASC_CYCLES(ASC)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .al_in(al_in),
    .ah_in(ah_in), .cf_in(cf_in), .hf_in(hf_in), .al_out(al_out),
    .ah_out(ah_out), .cf_out(cf_out), .hf_out(hf_out), .sf_out(sf_out),
    .zf_out(zf_out), .pf_out(pf_out), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [7:0] al, ah;
    logic c, h, s, z, p, asc;
    int due;
    string tag;
  } exp_t;

  exp_t sb[$];
  exp_t last;
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic exp_t model(logic [1:0] o, logic [7:0] a, logic [7:0] b,
                                 logic c, logic h);
    exp_t e;
    logic lo, hi;
    lo = h || (a[3:0] > 4'd9);
    hi = c || (a > 8'h99);
    e.al = a; e.ah = b; e.c = c; e.h = h; e.asc = o[1];
    case (o)
      2'b00: begin
        if (lo) begin e.al = e.al + 8'h06; e.h = 1; end
        if (hi) begin e.al = e.al + 8'h60; e.c = 1; end
      end
      2'b01: begin
        if (lo) begin e.al = e.al - 8'h06; e.h = 1; end
        if (hi) begin e.al = e.al - 8'h60; e.c = 1; end
      end
      default: begin
        if (lo) begin
          e.al = o[0] ? e.al - 8'h06 : e.al + 8'h06;
          e.ah = o[0] ? e.ah - 8'h01 : e.ah + 8'h01;
        end
        e.c = lo; e.h = lo;
        e.al = e.al & 8'h0f;
      end
    endcase
    e.s = e.al[7];
    e.z = (e.al == 8'h00);
    e.p = ~^e.al;
    return e;
  endfunction

  task automatic run_op(logic [1:0] o, logic [7:0] a, logic [7:0] b,
                        logic c, logic h, string tag, bit poke);
    exp_t e;
    @(negedge clk);
    while (busy) @(negedge clk);
    op = o; al_in = a; ah_in = b; cf_in = c; hf_in = h; start = 1'b1;
    e = model(o, a, b, c, h);
    e.due = cyc + 1 + (o[1] ? ASC : DEC);
    e.tag = tag;
    sb.push_back(e);
    last = e;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      @(negedge clk);
      op = ~o; al_in = ~a; ah_in = ~b; cf_in = ~c; hf_in = ~h; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (sb.size() != 0) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && done && !finished) begin
      if (sb.size() == 0) begin
        chk(0, "R10", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(al_out == e.al, e.tag, "AL", al_out, e.al);
        chk(ah_out == e.ah, e.tag, "AH", ah_out, e.ah);
        chk(cf_out == e.c, e.tag, "carry", cf_out, e.c);
        chk(hf_out == e.h, e.tag, "half-carry", hf_out, e.h);
        chk({sf_out, zf_out, pf_out} == {e.s, e.z, e.p}, "R5", "s/z/p",
            {sf_out, zf_out, pf_out}, {e.s, e.z, e.p});
        chk(cyc == e.due, "R9", "done cycle", cyc, e.due);
        chk(!busy, "R9", "busy during done", busy, 0);
        if (e.asc) chk(al_out[7:4] == 4'h0, "R8", "AL high nibble", al_out, e.al);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(0, "WATCHDOG", "timeout", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; op = 2'b00; al_in = 8'h00; ah_in = 8'h00;
    cf_in = 1'b0; hf_in = 1'b0;
    repeat (3) @(negedge clk);
    chk({busy, done, al_out, ah_out, cf_out, hf_out, sf_out, zf_out, pf_out} == '0,
        "R1", "state in reset", al_out, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({busy, done, al_out, ah_out, cf_out, hf_out, sf_out, zf_out, pf_out} == '0,
        "R1", "state after reset", al_out, 0);

    run_op(2'b00, 8'h0A, 8'h00, 0, 0, "R2", 0);
    run_op(2'b00, 8'h12, 8'h00, 0, 1, "R2", 0);
    run_op(2'b00, 8'h35, 8'h00, 0, 0, "R2", 0);
    run_op(2'b00, 8'h9A, 8'h00, 0, 0, "R3", 0);
    run_op(2'b00, 8'h45, 8'h00, 1, 0, "R3", 0);
    run_op(2'b00, 8'hA3, 8'h00, 0, 0, "R3", 0);
    run_op(2'b01, 8'h0F, 8'h00, 0, 0, "R4", 0);
    run_op(2'b01, 8'hA0, 8'h00, 0, 0, "R4", 0);
    run_op(2'b01, 8'h00, 8'h00, 1, 1, "R4", 0);
    run_op(2'b10, 8'h0B, 8'h01, 0, 0, "R6", 0);
    run_op(2'b10, 8'h35, 8'h07, 1, 0, "R6", 0);
    run_op(2'b10, 8'h02, 8'hFF, 0, 1, "R6", 0);
    run_op(2'b11, 8'h0B, 8'h05, 0, 0, "R7", 0);
    run_op(2'b11, 8'h00, 8'h00, 0, 1, "R7", 0);
    run_op(2'b11, 8'hF4, 8'h03, 1, 0, "R7", 0);
    run_op(2'b00, 8'h99, 8'h00, 0, 0, "R10", 1);
    run_op(2'b11, 8'h7C, 8'h10, 0, 0, "R10", 1);

    repeat (6) @(negedge clk);
    chk(al_out == last.al && ah_out == last.ah, "R11", "held AL", al_out, last.al);
    chk(!busy && !done, "R11", "idle after done", {busy, done}, 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule